// File: doc/BRIEF.md
# IrDA SIR pulse decoder

This block turns the short return-to-zero pulses delivered by an infrared receiver into a plain UART receive line for a host. The raw infrared input is asynchronous. It passes through a synchroniser into the system clock domain. A counter-based filter then discards low pulses that are too short to be real. The filter threshold is set in absolute time (nanoseconds), so it does not depend on the baud rate.

Every accepted pulse opens a window in which the UART line is driven low for one full bit period. A bit period is sixteen beats of a 16x bit-clock strobe. Windows always begin and end on that strobe grid. A pulse accepted while a window is open opens the next window at the boundary of the current one, so consecutive zero bits come out as one unbroken low level.

A busy flag runs from pulse acceptance to the end of the stretched bit. A companion encoder uses it to keep the half-duplex link quiet while data is arriving.

Top module: `irdec_top`

## Requirements
- R1: While rst_ni is low, rx_o is high and rx_busy_o is low, immediately and without a clock. After reset is released, no window left over from before the reset appears.
- R2: A low level on the synchronised infrared input that lasts at least FILT_CYC consecutive system clocks is accepted. FILT_CYC is SYS_CLK_KHZ*FILT_NS/1e6, which is 20 with the defaults.
- R3: A low level that lasts fewer than FILT_CYC consecutive system clocks has no effect on rx_o or rx_busy_o.
- R4: Each accepted pulse drives rx_o low for exactly TICKS_PER_BIT (16) strobe intervals, that is TICKS_PER_BIT*period system clocks for a periodic tick16_i.
- R5: rx_o falls on the first tick16_i edge at or after acceptance. Counted from the first clock that samples rxir_i low, this is between FILT_CYC+2 and FILT_CYC+1+P system clocks, where P is the strobe period in clocks.
- R6: rx_o low always implies rx_busy_o high. rx_busy_o rises at acceptance and falls together with the return of rx_o to high.
- R7: A pulse accepted while a window is open starts the next window exactly where the current one ends, so rx_o stays low for 2*TICKS_PER_BIT intervals without a gap.
- R8: With rxir_i held high, rx_o stays high and rx_busy_o stays low.
- R9: One continuous low run on rxir_i yields exactly one window, even if the run outlasts the window.
- R10: Outside reset, rx_o changes only on a clock edge at which tick16_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | One-cycle strobe, 16 per bit period |
| rxir_i | input | 1 | Asynchronous infrared receiver output, low pulse marks a zero bit |
| rx_o | output | 1 | UART receive line to the host, idles high |
| rx_busy_o | output | 1 | High from pulse acceptance to the end of the stretched bit |

## Verification
The checker watches several properties on every clock:
- the idle state is held during reset;
- rx_o is never low while the busy flag is clear;
- rx_o moves only on strobe edges;
- every window closes after a whole number of 16-strobe groups;
- the busy flag rises only after a synchronised low run of full threshold length.

The exact low duration of a single window, the acceptance latency and the rejection of pulses just below the threshold are only visible in the bench scenarios. The same holds for the one-window-per-run rule for very long pulses, the gap-free merging of back-to-back pulses, and the absence of a leftover window after a reset in mid-bit.

// File: rtl/irdec_pkg.sv
package irdec_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_LOW  = 1'b1
  } win_st_e;

  // system clocks covering a span given in ns
  function automatic int unsigned filt_cycles(input int unsigned clk_khz, input int unsigned span_ns);
    return (clk_khz * span_ns) / 1_000_000;
  endfunction

endpackage

// File: rtl/irdec_sync.sv
module irdec_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= RST_VAL;
        else         chain_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= RST_VAL;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irdec_glitch.sv
module irdec_glitch #(
  parameter int unsigned FILT_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_s_i,
  output logic acc_o
);

  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(FILT_CYC);

  logic          low;
  logic [CW-1:0] run_q;

  assign low   = !rx_s_i;
  // single strobe per low run (R2, R9); shorter runs never reach LAST (R3)
  assign acc_o = low && (run_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (!low)          run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + 1'b1;
  end

endmodule

// File: rtl/irdec_stretch.sv
module irdec_stretch
  import irdec_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic acc_i,
  output logic low_o,
  output logic busy_o
);

  localparam int unsigned TW = $clog2(TICKS_PER_BIT);
  localparam logic [TW-1:0] T_LAST = TW'(TICKS_PER_BIT - 1);

  win_st_e       st_q, st_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          pend_q, pend_d;
  logic          req, at_end;

  assign req    = pend_q | acc_i;
  assign at_end = (st_q == WIN_LOW) && (tcnt_q == T_LAST);

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    pend_d = req;
    if (tick_i) begin
      unique case (st_q)
        WIN_IDLE: begin
          if (req) begin
            st_d   = WIN_LOW;
            tcnt_d = '0;
            pend_d = 1'b0;
          end
        end
        WIN_LOW: begin
          if (at_end) begin
            tcnt_d = '0;
            if (req) pend_d = 1'b0;   // back-to-back window on the boundary (R7)
            else     st_d   = WIN_IDLE;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
        default: st_d = WIN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WIN_IDLE;
      tcnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
    end
  end

  assign low_o  = (st_q == WIN_LOW);
  assign busy_o = low_o | pend_q;

endmodule

// File: rtl/irdec_top.sv
module irdec_top #(
  parameter int unsigned SYS_CLK_KHZ   = 20000,
  parameter int unsigned FILT_NS       = 1000,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick16_i,
  input  logic rxir_i,
  output logic rx_o,
  output logic rx_busy_o
);

  localparam int unsigned FILT_CYC = irdec_pkg::filt_cycles(SYS_CLK_KHZ, FILT_NS);

  logic rxir_s;
  logic acc;
  logic win_low;

  irdec_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxir_i),
    .q_o   (rxir_s)
  );

  irdec_glitch #(
    .FILT_CYC(FILT_CYC)
  ) u_glitch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_s_i(rxir_s),
    .acc_o (acc)
  );

  irdec_stretch #(
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_stretch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick16_i),
    .acc_i (acc),
    .low_o (win_low),
    .busy_o(rx_busy_o)
  );

  // registered state, async reset drives idle high (R1)
  assign rx_o = !win_low;

endmodule

// File: rtl/irdec_chk.sv
module irdec_chk #(
  parameter int unsigned FILT_CYC      = 20,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick16_i,
  input logic rxir_s_i,
  input logic rx_o,
  input logic busy_o
);

  localparam int unsigned RW = $clog2(FILT_CYC + 1);
  localparam int unsigned TW = $clog2(TICKS_PER_BIT);
  localparam logic [RW-1:0] RUN_FULL = RW'(FILT_CYC);
  localparam logic [TW-1:0] T_LAST   = TW'(TICKS_PER_BIT - 1);

  logic [RW-1:0] run_q;
  logic [TW-1:0] wt_q;
  logic          wseen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (rxir_s_i)        run_q <= '0;
    else if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_q    <= '0;
      wseen_q <= 1'b0;
    end else if (rx_o) begin
      wt_q    <= '0;
      wseen_q <= 1'b0;
    end else if (tick16_i) begin
      wt_q    <= (wt_q == T_LAST) ? '0 : wt_q + 1'b1;
      wseen_q <= 1'b1;
    end
  end

  p_rst_idle_r1: assert property (@(posedge clk_i) !rst_ni |-> (rx_o && !busy_o));

  p_accept_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (run_q == RUN_FULL));

  p_window_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_o) |-> (wseen_q && wt_q == '0));

  p_low_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_o |-> busy_o);

  p_tick_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_o) |-> $past(tick16_i));

endmodule

bind irdec_top irdec_chk #(
  .FILT_CYC     (FILT_CYC),
  .TICKS_PER_BIT(TICKS_PER_BIT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick16_i(tick16_i),
  .rxir_s_i(rxir_s),
  .rx_o    (rx_o),
  .busy_o  (rx_busy_o)
);

// File: tb/irdec_top_tb_top.sv
`timescale 1ns/1ps
module irdec_top_tb_top;

  localparam int CLK_PERIOD  = 50;
  localparam int SYS_CLK_KHZ = 20000;
  localparam int FILT_NS     = 1000;
  localparam int FILT_CYC    = SYS_CLK_KHZ * FILT_NS / 1000000;
  localparam int TICKS       = 16;
  localparam int TICK_DIV    = 10;
  localparam int WIN_CYC     = TICKS * TICK_DIV;
  localparam int NVEC        = 8;
  localparam int VEC_LEN [NVEC] = '{5, 13, 19, 20, 21, 30, 60, 200};
  localparam bit VEC_ACC [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxir = 1'b1;
  logic rx, busy;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, lowcnt = 0, busycnt = 0, last_fall = -1, cur_run = 0, last_run = 0, bad_edge = 0;
  logic prev_rx = 1'b1, prev_rst = 1'b0, tick_pos = 1'b0;
  bit done = 1'b0;

  irdec_top #(
    .SYS_CLK_KHZ  (SYS_CLK_KHZ),
    .FILT_NS      (FILT_NS),
    .TICKS_PER_BIT(TICKS),
    .SYNC_STAGES  (2)
  ) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick16_i (tick),
    .rxir_i   (rxir),
    .rx_o     (rx),
    .rx_busy_o(busy)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  always @(posedge clk) tick_pos <= tick;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rx) begin lowcnt = lowcnt + 1; cur_run = cur_run + 1; end
    if (busy) busycnt = busycnt + 1;
    if (!rx && prev_rx) last_fall = cyc;
    if (rx && !prev_rx) last_run = cur_run;
    if (rx) cur_run = 0;
    if (rst_n && prev_rst && (rx !== prev_rx) && !tick_pos) bad_edge = bad_edge + 1;
    prev_rx = rx;
    prev_rst = rst_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(input int len);
    @(negedge clk); #1;
    rxir = 1'b0;
    repeat (len) @(negedge clk);
    #1;
    rxir = 1'b1;
  endtask

  initial begin
    int l0, b0, t0;
    idle(5);
    chk(rx === 1'b1 && busy === 1'b0, "R1 reset idle", {30'd0, rx, busy}, 2);
    rst_n = 1'b1;
    idle(20);

    // R8: idle line
    l0 = lowcnt; b0 = busycnt;
    idle(300);
    chk(lowcnt == l0, "R8 rx stays high", lowcnt - l0, 0);
    chk(busycnt == b0, "R8 busy stays low", busycnt - b0, 0);

    // vector table: low-run length vs acceptance
    for (int i = 0; i < NVEC; i++) begin
      int dl, db, lat;
      l0 = lowcnt; b0 = busycnt;
      @(negedge clk); #1;
      t0 = cyc;
      rxir = 1'b0;
      repeat (VEC_LEN[i]) @(negedge clk);
      #1;
      rxir = 1'b1;
      idle(WIN_CYC + 60);
      dl = lowcnt - l0;
      db = busycnt - b0;
      if (VEC_ACC[i]) begin
        chk(dl == WIN_CYC, "R2 R4 low cycles", dl, WIN_CYC);
        chk(last_run == WIN_CYC, "R4 contiguous window", last_run, WIN_CYC);
        lat = last_fall - t0;
        chk(lat >= FILT_CYC + 2 && lat <= FILT_CYC + 1 + TICK_DIV, "R5 latency", lat, FILT_CYC + 2);
        chk(db >= WIN_CYC && db < WIN_CYC + TICK_DIV, "R6 busy span", db, WIN_CYC);
        if (VEC_LEN[i] > WIN_CYC) chk(dl == WIN_CYC, "R9 one window per run", dl, WIN_CYC);
      end else begin
        chk(dl == 0, "R3 short pulse rx", dl, 0);
        chk(db == 0, "R3 short pulse busy", db, 0);
      end
    end

    // R7: second pulse inside open window
    l0 = lowcnt;
    pulse(30);
    idle(70);
    pulse(30);
    idle(2 * WIN_CYC + 100);
    chk(lowcnt - l0 == 2 * WIN_CYC, "R7 total low", lowcnt - l0, 2 * WIN_CYC);
    chk(last_run == 2 * WIN_CYC, "R7 gap-free merge", last_run, 2 * WIN_CYC);

    // R1: reset in mid-window
    pulse(30);
    idle(60);
    chk(rx === 1'b0, "R4 window open before reset", {31'd0, rx}, 0);
    rst_n = 1'b0;
    #1;
    chk(rx === 1'b1 && busy === 1'b0, "R1 async reset mid-window", {30'd0, rx, busy}, 2);
    idle(5);
    rst_n = 1'b1;
    l0 = lowcnt; b0 = busycnt;
    idle(300);
    chk(lowcnt == l0, "R1 no leftover window", lowcnt - l0, 0);
    chk(busycnt == b0, "R1 no leftover busy", busycnt - b0, 0);

    chk(bad_edge == 0, "R10 rx moves on tick only", bad_edge, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule